// File: doc/BRIEF.md
# Per-Pin Transition Capture Latch Bank

This block sits behind a group of general-purpose port inputs. For every pin it brings the raw level into the clock domain, watches for any change of level, and on the first change freezes the new level and raises a sticky flag. Software sees two vectors at all times: the per-pin level (live while a cell is armed, frozen once it has fired) and the per-pin flag. A write strobe with a data vector re-arms every cell whose data bit is 1; cells whose bit is 0 are left alone.

Each cell is a three-state machine. ARMED (`CELL_OPEN`): the level output follows the synchronized pin and the flag reads 0. FIRED (`CELL_HELD`): the level is frozen and the flag reads 1. FIRED_AGAIN (`CELL_HELD_PEND`): frozen, flag 1, and at least one further change has happened since firing. The transitions are: capture (ARMED to FIRED on a change), repeat (FIRED to FIRED_AGAIN on a change), release (FIRED to ARMED on a re-arm with no change), report (FIRED_AGAIN to FIRED on a re-arm, loading the present level so the remembered change shows up at once), and collide (any FIRED state to FIRED on a re-arm in the same cycle as a change, loading the new level).

A pin used as a plain input is served by re-arming it once and then reading the level vector while no change is captured, or by re-arming before each read.

Top module: `port_capture_bank`

## Requirements
- R1: After reset every flag reads 0 and every cell is armed, so the level output follows its pin.
- R2: Each pin passes through two synchronizing flops; with the cell armed, a pin change appears on the level output two clock edges later and the flag rises on the third edge.
- R3: A rising change and a falling change of a pin both set that pin's flag to 1.
- R4: Once a flag is 1, the level output holds the level the pin had just after the capturing change, whatever the pin does afterwards, until a re-arm.
- R5: A write with a data bit of 0 leaves that pin's flag and held level unchanged.
- R6: A write with a data bit of 1 to a fired cell that saw no later change clears the flag on the next edge and the level output follows the pin again.
- R7: If the pin changed while its cell was fired, a re-arm write leaves the flag at 1 on the next edge and the level output shows the pin's present synchronized level; a second re-arm with no further change then clears the flag.
- R8: Each pin's cell is independent: changes and writes on one bit do not alter the flag or level of any other bit.
- R9: When a re-arm write meets a detected change of the same pin in the same cycle, the change wins: the flag stays 1, the level output holds the new level, and no change is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | PINS | Raw asynchronous pin levels |
| wr_en_i | input | 1 | Re-arm write strobe, one cycle per write |
| wr_data_i | input | PINS | Per-bit re-arm command, 1 = re-arm, 0 = no effect |
| level_o | output | PINS | Live level when armed, frozen level when fired |
| flag_o | output | PINS | Sticky change flag, 1 = a change was captured |

## Verification
The re-arm command and a newly detected change of the same pin can land on one clock edge. The bench provokes this by toggling a fired pin and raising the write strobe exactly on the cycle in which the change leaves the synchronizer, two edges after the pin moves. It then judges that the flag is still 1, that the level output shows the new level, and that a further plain re-arm clears the flag, which proves nothing was left pending.

// File: rtl/port_capture_pkg.sv
package port_capture_pkg;
    typedef enum logic [1:0] {
        CELL_OPEN      = 2'd0,
        CELL_HELD      = 2'd1,
        CELL_HELD_PEND = 2'd2
    } cell_state_e;
endpackage

// File: rtl/port_sync.sv
module port_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/port_capture_cell.sv
module port_capture_cell
    import port_capture_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cur_i,
    input  logic rearm_i,
    output logic level_o,
    output logic flag_o
);
    cell_state_e state_q, state_d;
    logic        prev_q;
    logic        held_q, held_d;
    logic        change;

    assign change = cur_i ^ prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CELL_OPEN;
            prev_q  <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= cur_i;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            CELL_OPEN: begin
                if (change) begin
                    state_d = CELL_HELD;
                    held_d  = cur_i;
                end
            end
            CELL_HELD: begin
                if (change && rearm_i) begin
                    state_d = CELL_HELD;
                    held_d  = cur_i;
                end else if (change) begin
                    state_d = CELL_HELD_PEND;
                end else if (rearm_i) begin
                    state_d = CELL_OPEN;
                end
            end
            CELL_HELD_PEND: begin
                if (rearm_i) begin
                    state_d = CELL_HELD;
                    held_d  = cur_i;
                end
            end
            default: begin
                state_d = CELL_OPEN;
            end
        endcase
    end

    always_comb begin
        flag_o  = (state_q != CELL_OPEN);
        level_o = (state_q == CELL_OPEN) ? cur_i : held_q;
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CELL_OPEN && change) |=> (flag_o && level_o == $past(cur_i)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CELL_OPEN && !rearm_i) |=> (flag_o && $stable(level_o)));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CELL_HELD && rearm_i && !change) |=> !flag_o);

    p_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CELL_HELD_PEND && rearm_i) |=> (flag_o && level_o == $past(cur_i)));

    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && rearm_i && change) |=> (flag_o && level_o == $past(cur_i)));
endmodule

// File: rtl/port_capture_bank.sv
module port_capture_bank #(
    parameter int PINS        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_i,
    input  logic            wr_en_i,
    input  logic [PINS-1:0] wr_data_i,
    output logic [PINS-1:0] level_o,
    output logic [PINS-1:0] flag_o
);
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] rearm;

    assign rearm = wr_data_i & {PINS{wr_en_i}};

    port_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_cell
        port_capture_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur_i   (pin_sync[g]),
            .rearm_i (rearm[g]),
            .level_o (level_o[g]),
            .flag_o  (flag_o[g])
        );
    end

    p_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && flag_o[0] && !wr_data_i[0] && pin_sync[0] == $past(pin_sync[0]))
        |=> (flag_o[0] && $stable(level_o[0])));
endmodule

// File: tb/port_capture_bank_tb.sv
`timescale 1ns/1ps
module port_capture_bank_tb;
    localparam int PINS = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PINS-1:0] pin_i = '0;
    logic            wr_en_i = 1'b0;
    logic [PINS-1:0] wr_data_i = '0;
    logic [PINS-1:0] level_o;
    logic [PINS-1:0] flag_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    port_capture_bank #(.PINS(PINS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .level_o   (level_o),
        .flag_o    (flag_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rearm(input logic [PINS-1:0] mask);
        wr_en_i = 1'b1; wr_data_i = mask;
        step(1);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic t_reset();
        check("R1 flags after reset", flag_o, 4'h0);
        pin_i = 4'b0101;
        step(2);
        check("R1 armed level follows pin", level_o, 4'b0101);
        check("R2 flag rises on third edge only", flag_o, 4'h0);
        step(1);
        check("R2 flag after third edge", flag_o, 4'b0101);
        rearm(4'hF);
        step(2);
        check("R6 flags cleared by rearm", flag_o, 4'h0);
    endtask

    task automatic t_capture_both();
        pin_i[1] = 1'b1;
        step(3);
        check("R3 rising sets flag", flag_o, 4'b0010);
        pin_i[1] = 1'b0;
        step(4);
        check("R4 held level after rise", level_o, 4'b0111);
        pin_i[3] = 1'b1; pin_i[2] = 1'b0;
        step(3);
        check("R3 falling sets flag", flag_o[2], 1'b1);
        check("R4 held falling level", level_o[2], 1'b0);
        check("R8 other bits independent", level_o[3:2], 2'b10);
    endtask

    task automatic t_zero_write();
        rearm(4'b0001);
        check("R5 zero bits untouched flag", flag_o[3:1], 3'b111);
        check("R5 zero bits untouched level", level_o[3:1], 3'b101);
        check("R8 write on bit0 only", flag_o[0], 1'b0);
    endtask

    task automatic t_release();
        rearm(4'b1000);
        check("R6 flag clear after rearm", flag_o[3], 1'b0);
        check("R6 level follows pin", level_o[3], 1'b1);
        pin_i[3] = 1'b0; pin_i[0] = 1'b1;
        step(2);
        check("R6 live level after release", level_o[3], 1'b0);
        step(1);
        rearm(4'b1001);
        step(2);
    endtask

    task automatic t_pending();
        check("R7 precondition bit1 fired", flag_o[1], 1'b1);
        check("R7 frozen before report", level_o[1], 1'b1);
        rearm(4'b0010);
        check("R7 flag stays after report", flag_o[1], 1'b1);
        check("R7 level shows present pin", level_o[1], 1'b0);
        rearm(4'b0010);
        check("R7 second rearm clears", flag_o[1], 1'b0);
    endtask

    task automatic t_collide();
        rearm(4'b0100);
        pin_i[2] = 1'b1;
        step(3);
        check("R9 setup fired", {flag_o[2], level_o[2]}, 2'b11);
        pin_i[2] = 1'b0;
        step(2);
        rearm(4'b0100);
        check("R9 change wins flag", flag_o[2], 1'b1);
        check("R9 new level held", level_o[2], 1'b0);
        rearm(4'b0100);
        check("R9 nothing pending", flag_o[2], 1'b0);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_capture_both();
        t_zero_write();
        t_release();
        t_pending();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule